// File: doc/BRIEF.md
# Parallel Command-Mode Panel Write Engine

This block feeds a display panel that keeps its own frame memory, over an 8080-style parallel write bus: an active-low chip select, an active-low write strobe and a data bus. Software programs four phase lengths and an enable bit, writes the frame size, and then issues a software trigger. The block then takes exactly width × height words from a ready/valid pixel stream. Each word is shaped into a write cycle made of write setup, strobe active and hold phases. Chip select setup applies once, before the first word of the frame.

When the last word of the frame has been written, the block sets a pending frame-done interrupt. The engine stays in triggering mode from the accepted trigger until software clears that interrupt. Trigger commands that arrive during that time are dropped, because a repeated trigger can reset the panel. The interface clock is expected to run at about twice htotal × vtotal × refresh, so that frame-done comes before the panel's next tearing-effect pulse.

Top module: `lcd_cmd_bus_writer`

## Requirements
- R1: After reset, `lcd_cs_n` and `lcd_wr_n` are 1, and `pix_ready`, `frame_irq` and `trig_busy` are 0.
- R2: The word written at address 0 sets the timing. Bits [19:16] are chip-select setup, [15:12] write setup, [11:8] strobe active, [7:4] hold, and bit 0 is the interface enable. After a trigger the engine spends the chip-select-setup number of clocks with only `lcd_cs_n` low. Each word then takes one clock with `pix_ready` high, write-setup clocks, active clocks with `lcd_wr_n` low, and hold clocks.
- R3: A phase field of 0 skips that phase. The exception is strobe active: a value of 0 still gives one clock of `lcd_wr_n` low.
- R4: A pixel word is accepted only in a clock where `pix_ready` is high and `pix_valid` is high. The accepted word is driven on `lcd_data` and holds steady for the whole time `lcd_wr_n` is low.
- R5: `lcd_cs_n` goes low on the clock edge that accepts the trigger. It stays low between words and rises only after the hold phase of the last word.
- R6: The word at address 2 holds width in bits [11:0] and height in bits [27:16]. The frame length is width × height, sampled when the trigger is accepted. Writes to this register during a frame do not change that frame.
- R7: A write to address 1 is a trigger only if bit 0 (8080 mode) and bit 1 (command) are both 1, the enable bit is set, and width and height are both nonzero. Otherwise it has no effect.
- R8: While `trig_busy` is high, trigger writes are ignored. This covers a frame in flight and also a finished frame whose interrupt is still pending.
- R9: On the clock edge that ends the hold phase of the last word, `frame_irq` is set and `trig_busy` stays high.
- R10: Writing a value with bit 0 set to address 3 while `frame_irq` is high clears both `frame_irq` and `trig_busy`. Writing 0, or writing while no interrupt is pending, has no effect.
- R11: The timing fields are sampled when the trigger is accepted. Writes to address 0 during a frame do not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 timing, 1 trigger, 2 size, 3 interrupt clear) |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | DW (16) | Pixel word |
| pix_ready | output | 1 | Engine takes a pixel word this clock |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DW (16) | Panel data bus |
| frame_irq | output | 1 | Frame-done interrupt pending |
| trig_busy | output | 1 | Triggering mode: frame in flight or interrupt not yet cleared |

## Verification
The assertions assume that register writes come in isolated single-clock strobes and that `cfg_addr` and `cfg_wdata` are steady while `cfg_wr_en` is high. They also assume that `pix_data` is steady in every clock where `pix_ready` and `pix_valid` are both high. The stimulus changes every input only at the falling clock edge and issues at most one register write per clock. It keeps `pix_valid` high and advances `pix_data` only after a handshake. Because of this, the only waiting in a frame is the handshake clock of each word, and the reference model can lay out every frame as a fixed list of expected clocks when the trigger is accepted.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CSS  = 3'd1,
    PH_WAIT = 3'd2,
    PH_WSET = 3'd3,
    PH_ACT  = 3'd4,
    PH_HOLD = 3'd5
  } phase_e;

  typedef struct packed {
    logic [3:0] css;
    logic [3:0] wset;
    logic [3:0] act;
    logic [3:0] hold;
  } bus_timing_t;

  localparam logic [1:0] ADDR_TIMING = 2'd0;
  localparam logic [1:0] ADDR_TRIG   = 2'd1;
  localparam logic [1:0] ADDR_SIZE   = 2'd2;
  localparam logic [1:0] ADDR_CLEAR  = 2'd3;

  localparam bus_timing_t TIMING_RESET = '{css: 4'd0, wset: 4'd0, act: 4'd1, hold: 4'd0};

  // Number of clocks spent in a phase; strobe active never shorter than one.
  function automatic logic [3:0] phase_len(phase_e p, bus_timing_t t);
    logic [3:0] n;
    case (p)
      PH_CSS:  n = t.css;
      PH_WSET: n = t.wset;
      PH_ACT:  n = (t.act == 4'd0) ? 4'd1 : t.act;
      PH_HOLD: n = t.hold;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  // Counter preload on phase entry (counts down to zero).
  function automatic logic [3:0] phase_load(phase_e p, bus_timing_t t);
    logic [3:0] n;
    n = phase_len(p, t);
    return (n == 4'd0) ? 4'd0 : n - 4'd1;
  endfunction

endpackage

// File: rtl/lcdw_regs.sv
module lcdw_regs
  import lcdw_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             frame_done,
  output bus_timing_t      timing,
  output logic [DIM_W-1:0] dim_w,
  output logic [DIM_W-1:0] dim_h,
  output logic             start,
  output logic             trig_mode,
  output logic             irq
);

  logic if_en;
  logic clear_hit;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  assign start = wr_en && (addr == ADDR_TRIG) && wdata[1] && wdata[0] && if_en &&
                 !trig_mode && (dim_w != '0) && (dim_h != '0);
  assign clear_hit = wr_en && (addr == ADDR_CLEAR) && wdata[0] && irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing <= TIMING_RESET;
      if_en  <= 1'b0;
      dim_w  <= '0;
      dim_h  <= '0;
    end else if (wr_en && addr == ADDR_TIMING) begin
      timing.css  <= wdata[19:16];
      timing.wset <= wdata[15:12];
      timing.act  <= wdata[11:8];
      timing.hold <= wdata[7:4];
      if_en       <= wdata[0];
    end else if (wr_en && addr == ADDR_SIZE) begin
      dim_w <= wdata[DIM_W-1:0];
      dim_h <= wdata[16 +: DIM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_mode <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (start)          trig_mode <= 1'b1;
      else if (clear_hit) trig_mode <= 1'b0;
      if (frame_done)     irq <= 1'b1;
      else if (clear_hit) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
  import lcdw_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  bus_timing_t      timing_in,
  input  logic [CNT_W-1:0] words_in,
  input  logic             pix_valid,
  input  logic [DW-1:0]    pix_data,
  output logic             pix_ready,
  output logic             cs_n,
  output logic             wr_n,
  output logic [DW-1:0]    bus_data,
  output logic             frame_done,
  output phase_e           phase
);

  bus_timing_t      t_q;
  logic [3:0]       cnt;
  logic [CNT_W-1:0] rem;
  logic             word_end;
  phase_e           after_act;
  phase_e           after_word;
  phase_e           after_take;

  assign after_act  = (t_q.hold != 4'd0) ? PH_HOLD : PH_IDLE;
  assign after_take = (t_q.wset != 4'd0) ? PH_WSET : PH_ACT;
  assign after_word = (rem == '0) ? PH_IDLE : PH_WAIT;

  assign word_end   = (cnt == 4'd0) &&
                      ((phase == PH_HOLD) || (phase == PH_ACT && after_act == PH_IDLE));
  assign frame_done = word_end && (rem == '0);

  assign pix_ready = (phase == PH_WAIT);
  assign cs_n      = (phase == PH_IDLE);
  assign wr_n      = (phase != PH_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= 4'd0;
      rem      <= '0;
      t_q      <= TIMING_RESET;
      bus_data <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          t_q   <= timing_in;
          rem   <= words_in;
          phase <= (timing_in.css != 4'd0) ? PH_CSS : PH_WAIT;
          cnt   <= phase_load(PH_CSS, timing_in);
        end
        PH_CSS: begin
          if (cnt == 4'd0) phase <= PH_WAIT;
          else             cnt   <= cnt - 4'd1;
        end
        PH_WAIT: if (pix_valid) begin
          bus_data <= pix_data;
          rem      <= rem - 1'b1;
          phase    <= after_take;
          cnt      <= phase_load(after_take, t_q);
        end
        PH_WSET: begin
          if (cnt == 4'd0) begin
            phase <= PH_ACT;
            cnt   <= phase_load(PH_ACT, t_q);
          end else cnt <= cnt - 4'd1;
        end
        PH_ACT: begin
          if (cnt != 4'd0)               cnt   <= cnt - 4'd1;
          else if (after_act == PH_HOLD) begin
            phase <= PH_HOLD;
            cnt   <= phase_load(PH_HOLD, t_q);
          end else                       phase <= after_word;
        end
        PH_HOLD: begin
          if (cnt == 4'd0) phase <= after_word;
          else             cnt   <= cnt - 4'd1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_cmd_bus_writer.sv
module lcd_cmd_bus_writer
  import lcdw_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DIM_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready,
  output logic          lcd_cs_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_data,
  output logic          frame_irq,
  output logic          trig_busy
);

  localparam int CNT_W = 2 * DIM_W;

  bus_timing_t      timing;
  logic [DIM_W-1:0] dim_w;
  logic [DIM_W-1:0] dim_h;
  logic [CNT_W-1:0] frame_words;
  logic             frame_start;
  logic             frame_done;
  phase_e           seq_phase;

  assign frame_words = CNT_W'(dim_w) * CNT_W'(dim_h);

  lcdw_regs #(.DIM_W(DIM_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .frame_done (frame_done),
    .timing     (timing),
    .dim_w      (dim_w),
    .dim_h      (dim_h),
    .start      (frame_start),
    .trig_mode  (trig_busy),
    .irq        (frame_irq)
  );

  lcdw_seq #(.DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .timing_in  (timing),
    .words_in   (frame_words),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .pix_ready  (pix_ready),
    .cs_n       (lcd_cs_n),
    .wr_n       (lcd_wr_n),
    .bus_data   (lcd_data),
    .frame_done (frame_done),
    .phase      (seq_phase)
  );

endmodule

// File: rtl/lcdw_chk.sv
module lcdw_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lcd_cs_n,
  input logic          lcd_wr_n,
  input logic [DW-1:0] lcd_data,
  input logic          pix_ready,
  input logic          frame_irq,
  input logic          trig_busy,
  input logic          frame_start,
  input logic          frame_done
);

  // R5
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);

  // R4
  take_outside_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (lcd_wr_n && !lcd_cs_n));

  // R4
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n && $past(!lcd_wr_n)) |-> $stable(lcd_data));

  // R5
  start_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!lcd_cs_n && trig_busy));

  // R9
  done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (frame_irq && trig_busy && lcd_cs_n));

  // R8
  select_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs_n |-> trig_busy);

  // R10
  irq_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> trig_busy);

endmodule

bind lcd_cmd_bus_writer lcdw_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lcd_cs_n    (lcd_cs_n),
  .lcd_wr_n    (lcd_wr_n),
  .lcd_data    (lcd_data),
  .pix_ready   (pix_ready),
  .frame_irq   (frame_irq),
  .trig_busy   (trig_busy),
  .frame_start (frame_start),
  .frame_done  (frame_done)
);

// File: tb/lcd_cmd_bus_writer_tb_top.sv
module lcd_cmd_bus_writer_tb_top;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [31:0]   cfg_wdata = 32'd0;
  logic          pix_valid = 1'b1;
  logic [DW-1:0] pix_data;
  logic          pix_ready, lcd_cs_n, lcd_wr_n, frame_irq, trig_busy;
  logic [DW-1:0] lcd_data;

  always #10 clk = ~clk;

  lcd_cmd_bus_writer #(.DW(DW), .DIM_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
    .lcd_data(lcd_data), .frame_irq(frame_irq), .trig_busy(trig_busy)
  );

  typedef struct {
    bit          cs_n;
    bit          wr_n;
    bit          rdy;
    bit          dchk;
    logic [15:0] d;
  } exp_t;

  exp_t   q[$];
  exp_t   cur;
  int     checks = 0;
  int     fails = 0;
  int     hs_cnt = 0;
  string  cur_req = "R1";
  bit     finished = 1'b0;

  int m_css = 0, m_ws = 0, m_act = 1, m_hold = 0, m_en = 0, m_w = 0, m_h = 0;
  bit m_busy = 0, m_irq = 0, m_frame = 0;

  function automatic logic [15:0] pat(int n);
    return 16'(n * 4951 + 165);
  endfunction

  function automatic exp_t mk(bit cs, bit wr, bit r, bit dc, logic [15:0] d);
    exp_t e;
    e.cs_n = cs; e.wr_n = wr; e.rdy = r; e.dchk = dc; e.d = d;
    return e;
  endfunction

  task automatic build_frame();
    int a;
    a = (m_act == 0) ? 1 : m_act;
    for (int i = 0; i < m_css; i++) q.push_back(mk(0, 1, 0, 0, 16'h0));
    for (int k = 0; k < m_w * m_h; k++) begin
      q.push_back(mk(0, 1, 1, 0, 16'h0));
      for (int i = 0; i < m_ws; i++) q.push_back(mk(0, 1, 0, 0, 16'h0));
      for (int i = 0; i < a; i++) q.push_back(mk(0, 0, 0, 1, pat(hs_cnt + k)));
      for (int i = 0; i < m_hold; i++) q.push_back(mk(0, 1, 0, 0, 16'h0));
    end
  endtask

  task automatic model_step();
    if (cfg_wr_en) begin
      case (cfg_addr)
        2'd0: begin
          m_css = int'(cfg_wdata[19:16]); m_ws = int'(cfg_wdata[15:12]);
          m_act = int'(cfg_wdata[11:8]);  m_hold = int'(cfg_wdata[7:4]);
          m_en = int'(cfg_wdata[0]);
        end
        2'd1: if (cfg_wdata[1] && cfg_wdata[0] && m_en != 0 && !m_busy && m_w != 0 && m_h != 0) begin
          m_busy = 1; m_frame = 1; build_frame();
        end
        2'd2: begin m_w = int'(cfg_wdata[11:0]); m_h = int'(cfg_wdata[27:16]); end
        default: if (cfg_wdata[0] && m_irq) begin m_irq = 0; m_busy = 0; end
      endcase
    end
    if (q.size() > 0) cur = q.pop_front();
    else begin
      cur = mk(1, 1, 0, 0, 16'h0);
      if (m_frame) begin m_irq = 1; m_frame = 0; end
    end
  endtask

  task automatic compare();
    bit bad;
    checks++;
    bad = (lcd_cs_n !== cur.cs_n) || (lcd_wr_n !== cur.wr_n) || (pix_ready !== cur.rdy) ||
          (frame_irq !== m_irq) || (trig_busy !== m_busy) || (cur.dchk && lcd_data !== cur.d);
    if (bad) begin
      fails++;
      $display("FAIL %s t=%0t actual cs_n=%0b wr_n=%0b rdy=%0b irq=%0b busy=%0b data=%h expected cs_n=%0b wr_n=%0b rdy=%0b irq=%0b busy=%0b data=%h",
               cur_req, $time, lcd_cs_n, lcd_wr_n, pix_ready, frame_irq, trig_busy, lcd_data,
               cur.cs_n, cur.wr_n, cur.rdy, m_irq, m_busy, cur.dchk ? cur.d : lcd_data);
    end
  endtask

  task automatic tick();
    bit hs;
    model_step();
    hs = pix_ready && pix_valid;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (hs) hs_cnt++;
    pix_data = pat(hs_cnt);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && q.size() > 0; i++) tick();
    idle(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    pix_data = pat(0);
    cur = mk(1, 1, 0, 0, 16'h0);
    repeat (3) @(negedge clk);
    compare();                                  // R1 during reset
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R7"; wr(2'd0, 32'h0000_1000);    // enable clear
    wr(2'd2, {16'd1, 16'd2});
    wr(2'd1, 32'h3); idle(4);                   // ignored: enable off

    cur_req = "R2"; wr(2'd0, 32'h0002_1311);    // css2 ws1 act3 hold1 en
    wr(2'd2, {16'd2, 16'd3});
    wr(2'd1, 32'h3);
    cur_req = "R4"; idle(6);
    cur_req = "R8";  wr(2'd1, 32'h3);           // trigger during frame
    cur_req = "R11"; wr(2'd0, 32'h000F_FFF1);   // timing change mid-frame
    cur_req = "R6";  wr(2'd2, {16'd1, 16'd1});  // size change mid-frame
    cur_req = "R10"; wr(2'd3, 32'h1);           // clear with nothing pending
    cur_req = "R5"; drain();
    cur_req = "R8";  wr(2'd1, 32'h3); idle(3);  // pending irq: still busy
    cur_req = "R10"; wr(2'd3, 32'h0); idle(2);
    wr(2'd3, 32'h1); idle(3);

    cur_req = "R3"; wr(2'd0, 32'h0000_0001);    // all phases zero
    wr(2'd2, {16'd1, 16'd4});
    wr(2'd1, 32'h3); drain();
    cur_req = "R9"; idle(2);
    wr(2'd3, 32'h1); idle(2);

    cur_req = "R7"; wr(2'd1, 32'h2); idle(3);   // mode bit clear
    wr(2'd1, 32'h1); idle(3);                   // command bit clear
    wr(2'd2, 32'h0); wr(2'd1, 32'h3); idle(3);  // zero size

    cur_req = "R2"; wr(2'd0, 32'h000F_FFF1);    // longest phases
    wr(2'd2, {16'd1, 16'd2});
    wr(2'd1, 32'h3); drain();
    cur_req = "R10"; wr(2'd3, 32'h1); idle(3);

    cur_req = "R6"; wr(2'd0, 32'h0001_0201);
    wr(2'd2, {16'd3, 16'd1});
    wr(2'd1, 32'h3); drain();
    wr(2'd3, 32'h1); idle(3);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule